// File: doc/BRIEF.md
# Audio sample rate classifier

This block works out which standard audio sampling rate an incoming stream runs at. It receives a one-cycle frame strobe per audio frame, already synchronised to a fixed 24.576 MHz reference clock. It counts reference cycles between strobes and adds up eight successive frame intervals into one window total. At the end of each window it compares that total against acceptance bands for thirteen standard rates, from 8 kHz to 192 kHz, and reports a rate code with a valid bit.

Two further outputs come from the same measurement. A high-rate indicator has hysteresis, so a rate that wanders between roughly 54 kHz and 64 kHz does not make it toggle. An unlock flag compares each single-frame interval with the one before it. The flag sets when the sync interval jumps, and it clears only after the stream has been steady again for two intervals. Downstream logic uses the code to choose clock dividers. It uses the indicator to choose a double-rate or quad-rate path, and it uses the unlock flag to mute while the source is unsettled.

Top module: `srate_classifier`

## Requirements
- R1: While reset is asserted and after it is released, until the first window completes, `rate_code` is 15, `rate_valid` is 0 and `rate_high` is 0. `unlock` is 1 until the stream has proven steady (see R8).
- R2: A frame interval is the number of reference cycles from one sampled strobe to the next. The first strobe after reset only opens measurement. Each group of 8 consecutive intervals forms a window. `rate_code`, `rate_valid` and `rate_high` change only in the cycle after the strobe that closes a window, and they hold between windows.
- R3: The rate codes follow ascending frequency. The codes are: 0 = 8 kHz, 1 = 11.025 kHz, 2 = 16 kHz, 3 = 22.05 kHz, 4 = 24 kHz, 5 = 32 kHz, 6 = 44.1 kHz, 7 = 48 kHz, 8 = 64 kHz, 9 = 88.2 kHz, 10 = 96 kHz, 11 = 176.4 kHz and 12 = 192 kHz. Code 15 always goes with `rate_valid` = 0, and a valid code is never above 12.
- R4: The nominal window total for a rate f is round(24,576,000 × 8 / f). For example, this is 4096 at 48 kHz and 24576 at 8 kHz. A total is accepted for f when it lies within nominal ± floor(nominal × 3 / 100), with both bounds inclusive. For 48 kHz that band is 3974 to 4218. A total outside every band gives code 15 with `rate_valid` = 0.
- R5: `rate_high` sets when a window total is at most 3072 reference cycles, which means a rate of 64 kHz or faster.
- R6: `rate_high` clears when a window total exceeds 3640 cycles, which means a rate below about 54 kHz. For totals from 3073 to 3640 it keeps its previous value, whether or not the total matches a rate.
- R7: An interval is irregular when its difference from the previous interval, times 50, is greater than the previous interval. This is a change of more than 2 %. An irregular interval sets `unlock` in the cycle after its closing strobe.
- R8: `unlock` clears after two consecutive intervals that are each consistent with the one before. The first interval after reset has no predecessor and counts toward neither outcome. An irregular interval restarts the count of consistent intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse per audio frame, synchronous to `clk` |
| rate_code | output | 4 | Detected rate code (0 to 12), or 15 when unknown |
| rate_valid | output | 1 | High when the last window total matched a rate band |
| rate_high | output | 1 | High-rate indicator with hysteresis |
| unlock | output | 1 | Set on an irregular sync interval |

## Verification
The bench goes after the edges of the acceptance bands. It sends 48 kHz windows that total exactly 3974, 3973, 4218 and 4219 cycles. A band computed with the wrong rounding, or with an exclusive bound, would flip valid on one of them. It walks the high-rate indicator through totals of 3073, 3072, 3640 and 3648, and through a rate with no band inside the hysteresis gap. A design that compared with the wrong strictness, or that cleared the flag whenever the code became unknown, would show the wrong level. For lock, it applies interval changes of exactly 10 and 11 cycles around 512, and an irregular interval in the middle of a recovery. An off-by-one jitter test, or a counter of consistent intervals that did not restart, would clear or set `unlock` one strobe early or late. It also checks that the code stays unknown until the eighth interval closes.

// File: rtl/srate_pkg.sv
package srate_pkg;

    localparam int NUM_RATES = 13;
    localparam int CODE_W    = 4;
    localparam logic [CODE_W-1:0] CODE_UNKNOWN = 4'd15;

    // Standard rates in ascending order; index equals output code.
    function automatic longint rate_hz(input int idx);
        case (idx)
            0:       return 64'd8000;
            1:       return 64'd11025;
            2:       return 64'd16000;
            3:       return 64'd22050;
            4:       return 64'd24000;
            5:       return 64'd32000;
            6:       return 64'd44100;
            7:       return 64'd48000;
            8:       return 64'd64000;
            9:       return 64'd88200;
            10:      return 64'd96000;
            11:      return 64'd176400;
            default: return 64'd192000;
        endcase
    endfunction

    // Rounded reference-cycle total expected over a window of frames.
    function automatic longint nominal_count(input longint ref_hz, input longint frames, input int idx);
        longint r;
        r = rate_hz(idx);
        return (ref_hz * frames + r / 2) / r;
    endfunction

    function automatic longint tol_band(input longint nom, input longint pct);
        return (nom * pct) / 100;
    endfunction

endpackage

// File: rtl/srate_period_meter.sv
module srate_period_meter #(
    parameter int PER_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    output logic             per_fire,
    output logic [PER_W-1:0] per_len
);

    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             started;
    } meter_t;

    meter_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        per_fire = frame_sync && st_q.started;
        per_len  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + PER_W'(1);
        if (frame_sync) begin
            st_d.cnt     = '0;
            st_d.started = 1'b1;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/srate_jitter_mon.sv
module srate_jitter_mon #(
    parameter int PER_W     = 13,
    parameter int JIT_DIV   = 50,
    parameter int GOOD_NEED = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_fire,
    input  logic [PER_W-1:0] per_len,
    output logic             unlock
);

    localparam int SC_W = PER_W + $clog2(JIT_DIV + 1);
    localparam int GW   = $clog2(GOOD_NEED + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_NEED - 1);

    typedef struct packed {
        logic [PER_W-1:0] prev;
        logic             have_prev;
        logic [GW-1:0]    good;
        logic             unlock;
    } jit_t;

    jit_t st_q, st_d;
    logic [PER_W-1:0] diff;
    logic [SC_W-1:0]  scaled;
    logic             irregular;

    always_comb begin
        st_d      = st_q;
        diff      = (per_len >= st_q.prev) ? per_len - st_q.prev : st_q.prev - per_len;
        scaled    = SC_W'(diff) * SC_W'(JIT_DIV);
        irregular = scaled > SC_W'(st_q.prev);
        if (per_fire) begin
            st_d.prev      = per_len;
            st_d.have_prev = 1'b1;
            if (st_q.have_prev) begin
                if (irregular) begin
                    st_d.unlock = 1'b1;
                    st_d.good   = '0;
                end else if (st_q.unlock) begin
                    if (st_q.good == GOOD_LAST) begin
                        st_d.unlock = 1'b0;
                        st_d.good   = '0;
                    end else begin
                        st_d.good = st_q.good + GW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.unlock <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlock = st_q.unlock;

endmodule

// File: rtl/srate_window_acc.sv
module srate_window_acc #(
    parameter int PER_W       = 13,
    parameter int FRAMES_LOG2 = 3,
    parameter int ACC_W       = PER_W + FRAMES_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_fire,
    input  logic [PER_W-1:0] per_len,
    output logic             win_done,
    output logic [ACC_W-1:0] win_sum
);

    localparam logic [FRAMES_LOG2-1:0] IDX_LAST = '1;

    typedef struct packed {
        logic [ACC_W-1:0]       acc;
        logic [FRAMES_LOG2-1:0] idx;
    } win_t;

    win_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        win_sum  = st_q.acc + ACC_W'(per_len);
        win_done = per_fire && (st_q.idx == IDX_LAST);
        if (per_fire) begin
            if (st_q.idx == IDX_LAST) begin
                st_d.acc = '0;
                st_d.idx = '0;
            end else begin
                st_d.acc = win_sum;
                st_d.idx = st_q.idx + FRAMES_LOG2'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/srate_rate_lut.sv
module srate_rate_lut
    import srate_pkg::*;
#(
    parameter int REF_HZ  = 24576000,
    parameter int FRAMES  = 8,
    parameter int TOL_PCT = 3,
    parameter int ACC_W   = 16
) (
    input  logic [ACC_W-1:0]  win_sum,
    output logic [CODE_W-1:0] code,
    output logic              hit_any
);

    logic [NUM_RATES-1:0] hit;

    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_band
        localparam longint NOM = nominal_count(longint'(REF_HZ), longint'(FRAMES), gi);
        localparam longint TOL = tol_band(NOM, longint'(TOL_PCT));
        localparam logic [ACC_W-1:0] LO = ACC_W'(NOM - TOL);
        localparam logic [ACC_W-1:0] HI = ACC_W'(NOM + TOL);
        assign hit[gi] = (win_sum >= LO) && (win_sum <= HI);
    end

    always_comb begin
        code    = CODE_UNKNOWN;
        hit_any = |hit;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i]) begin
                code = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/srate_classifier.sv
module srate_classifier
    import srate_pkg::*;
#(
    parameter int REF_HZ      = 24576000,
    parameter int FRAMES_LOG2 = 3,
    parameter int TOL_PCT     = 3,
    parameter int JIT_DIV     = 50,
    parameter int GOOD_NEED   = 2,
    parameter int HIGH_SET_HZ = 64000,
    parameter int HIGH_CLR_HZ = 54000,
    parameter int MIN_RATE_HZ = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    output logic [CODE_W-1:0] rate_code,
    output logic              rate_valid,
    output logic              rate_high,
    output logic              unlock
);

    localparam int FRAMES = 1 << FRAMES_LOG2;
    localparam int PER_W  = $clog2(REF_HZ / MIN_RATE_HZ * 2 + 1);
    localparam int ACC_W  = PER_W + FRAMES_LOG2;
    localparam logic [ACC_W-1:0] SET_MAX = ACC_W'(longint'(REF_HZ) * FRAMES / HIGH_SET_HZ);
    localparam logic [ACC_W-1:0] CLR_MIN = ACC_W'(longint'(REF_HZ) * FRAMES / HIGH_CLR_HZ);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              high;
    } out_t;

    out_t st_q, st_d;

    logic              per_fire;
    logic [PER_W-1:0]  per_len;
    logic              win_done;
    logic [ACC_W-1:0]  win_sum;
    logic [CODE_W-1:0] lut_code;
    logic              lut_hit;

    srate_period_meter #(.PER_W(PER_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .per_fire(per_fire), .per_len(per_len)
    );

    srate_jitter_mon #(.PER_W(PER_W), .JIT_DIV(JIT_DIV), .GOOD_NEED(GOOD_NEED)) u_jit (
        .clk(clk), .rst_n(rst_n), .per_fire(per_fire), .per_len(per_len),
        .unlock(unlock)
    );

    srate_window_acc #(.PER_W(PER_W), .FRAMES_LOG2(FRAMES_LOG2), .ACC_W(ACC_W)) u_win (
        .clk(clk), .rst_n(rst_n), .per_fire(per_fire), .per_len(per_len),
        .win_done(win_done), .win_sum(win_sum)
    );

    srate_rate_lut #(.REF_HZ(REF_HZ), .FRAMES(FRAMES), .TOL_PCT(TOL_PCT), .ACC_W(ACC_W)) u_lut (
        .win_sum(win_sum), .code(lut_code), .hit_any(lut_hit)
    );

    always_comb begin
        st_d = st_q;
        if (win_done) begin
            st_d.code  = lut_code;
            st_d.valid = lut_hit;
            if (win_sum <= SET_MAX) begin
                st_d.high = 1'b1;
            end else if (win_sum > CLR_MIN) begin
                st_d.high = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code  <= CODE_UNKNOWN;
            st_q.valid <= 1'b0;
            st_q.high  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_code  = st_q.code;
    assign rate_valid = st_q.valid;
    assign rate_high  = st_q.high;

endmodule

// File: rtl/srate_classifier_chk.sv
module srate_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_sync,
    input logic [3:0] rate_code,
    input logic       rate_valid,
    input logic       rate_high,
    input logic       unlock
);

    a_r1_reset_vals: assert property (@(posedge clk)
        !rst_n |-> (rate_code == 4'd15) && !rate_valid && !rate_high && unlock);

    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(rate_code) && $stable(rate_valid));

    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> rate_code <= 4'd12);

    a_r3_unknown_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_valid |-> rate_code == 4'd15);

    a_r5_fast_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && rate_code >= 4'd9) |-> rate_high);

    a_r6_slow_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && rate_code <= 4'd7) |-> !rate_high);

    a_r6_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(rate_high));

    a_r7_unlock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(frame_sync));

    a_r8_unlock_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock) |-> $past(frame_sync));

endmodule

bind srate_classifier srate_classifier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .rate_code(rate_code), .rate_valid(rate_valid),
    .rate_high(rate_high), .unlock(unlock)
);

// File: tb/srate_classifier_bench.sv
module srate_classifier_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       frame_sync = 1'b0;
    logic [3:0] rate_code;
    logic       rate_valid;
    logic       rate_high;
    logic       unlock;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    srate_classifier u_srate_classifier (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .rate_code(rate_code), .rate_valid(rate_valid),
        .rate_high(rate_high), .unlock(unlock)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_sync = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse();
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic interval(input int n);
        repeat (n - 1) @(negedge clk);
        pulse();
    endtask

    task automatic block(input int n_base, input int n_last);
        for (int i = 0; i < 7; i++) interval(n_base);
        interval(n_last);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 code in reset", rate_code, 15);
        chk("R1 valid in reset", rate_valid, 0);
        chk("R1 high in reset", rate_high, 0);
        chk("R1 unlock in reset", unlock, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_lock_48k();
        do_reset();
        pulse();
        interval(512);
        chk("R8 no compare on first interval", unlock, 1);
        interval(512);
        chk("R8 one consistent interval", unlock, 1);
        interval(512);
        chk("R8 two consistent intervals", unlock, 0);
        for (int i = 0; i < 4; i++) interval(512);
        chk("R2 code held before window end", rate_code, 15);
        chk("R1 valid before first window", rate_valid, 0);
        interval(512);
        chk("R3 48k code", rate_code, 7);
        chk("R4 48k valid", rate_valid, 1);
        chk("R6 48k high", rate_high, 0);
    endtask

    task automatic t_rate(input string tag, input int n, input int exp_code, input int exp_high);
        do_reset();
        pulse();
        block(n, n);
        chk({"R3 code ", tag}, rate_code, exp_code);
        chk({"R4 valid ", tag}, rate_valid, 1);
        chk({"R5 high ", tag}, rate_high, exp_high);
    endtask

    task automatic t_band_edges();
        do_reset();
        pulse();
        block(527, 529);
        chk("R4 upper bound 4218 code", rate_code, 7);
        chk("R4 upper bound 4218 valid", rate_valid, 1);
        block(527, 530);
        chk("R4 beyond upper 4219 code", rate_code, 15);
        chk("R4 beyond upper 4219 valid", rate_valid, 0);
        block(497, 495);
        chk("R4 lower bound 3974 valid", rate_valid, 1);
        block(497, 494);
        chk("R4 below lower 3973 valid", rate_valid, 0);
        chk("R3 unknown code", rate_code, 15);
    endtask

    task automatic t_hysteresis();
        do_reset();
        pulse();
        block(128, 128);
        chk("R5 192k sets high", rate_high, 1);
        block(424, 424);
        chk("R6 gap total 3392 holds high", rate_high, 1);
        chk("R4 gap total 3392 invalid", rate_valid, 0);
        block(557, 557);
        chk("R3 44.1k code", rate_code, 6);
        chk("R6 44.1k clears high", rate_high, 0);
        block(424, 424);
        chk("R6 gap total 3392 holds low", rate_high, 0);
        block(384, 384);
        chk("R5 total 3072 sets high", rate_high, 1);
        chk("R3 64k code", rate_code, 8);
        block(455, 455);
        chk("R6 total 3640 holds high", rate_high, 1);
        block(456, 456);
        chk("R6 total 3648 clears high", rate_high, 0);
        block(384, 385);
        chk("R5 total 3073 keeps low", rate_high, 0);
        chk("R4 total 3073 is 64k", rate_code, 8);
        block(384, 384);
        chk("R5 total 3072 sets again", rate_high, 1);
    endtask

    task automatic t_jitter();
        do_reset();
        pulse();
        interval(512);
        interval(512);
        interval(512);
        chk("R8 locked at start", unlock, 0);
        interval(522);
        chk("R7 change of 10 tolerated", unlock, 0);
        interval(512);
        chk("R7 change back tolerated", unlock, 0);
        interval(523);
        chk("R7 change of 11 unlocks", unlock, 1);
        interval(523);
        chk("R8 first steady interval", unlock, 1);
        interval(523);
        chk("R8 second steady relocks", unlock, 0);
        interval(512);
        chk("R7 drop of 11 unlocks", unlock, 1);
        interval(512);
        chk("R8 one steady", unlock, 1);
        interval(523);
        chk("R8 irregular restarts count", unlock, 1);
        interval(523);
        chk("R8 restarted count one", unlock, 1);
        interval(523);
        chk("R8 restarted count two", unlock, 0);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock_48k();
        t_rate("8k", 3072, 0, 0);
        t_rate("11.025k", 2229, 1, 0);
        t_rate("96k", 256, 10, 1);
        t_rate("176.4k", 139, 11, 1);
        t_rate("192k", 128, 12, 1);
        t_band_edges();
        t_hysteresis();
        t_jitter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule